// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block stores incoming Ethernet frames in a local packet RAM that is split into 256-byte pages. The pages between a programmable low boundary page and a programmable high boundary page form a circular receive region. A frame arrives one byte per cycle on a simple input with an end-of-frame marker and a status byte. The block writes it four bytes into the page named by the write-page pointer and continues page by page, wrapping from the high boundary back to the low boundary. After the last byte it writes a 4-byte header at the start of the frame's first page. This header carries the page where the next frame will begin, the frame length and the status byte. The block then moves the write-page pointer to that next page.

Software reads frames through a byte-wide RAM read port. It follows the chain of headers and releases space by writing the next-page value of a consumed frame into the read-page pointer. If a frame would run into the page held by the read-page pointer, the frame is dropped and a buffer-full interrupt is raised. Depending on a recovery setting, reception then either continues with the next frame or stays halted until software acknowledges the full condition. Frames longer than the size limit are discarded. Interrupt flags for stored frames, frames carrying a receive error and the full condition are masked into one interrupt output.

Top module: `rx_page_ring`

## Requirements
- R1: After reset the write-page pointer, the read-page pointer and the low boundary all read 0x001. The high boundary reads 0x00F. Interrupt flags, mask and control read 0, and `irq` is low.
- R2: Register map (byte addresses). Write pointer: 0/1. Read pointer: 2/3. Low boundary: 4/5. High boundary: 6/7. Each 12-bit pointer keeps bits 7:0 at the even address and bits 11:8 in bits 3:0 of the odd address. Bits 7:4 of an odd address read as 0. Address 8 holds the interrupt flags: bit 0 frame stored, bit 1 receive error, bit 2 buffer full. Address 9 holds the mask. Address 10 is control: bit 0 enables automatic recovery, and bit 1 (read only) shows the halted state.
- R3: Data byte i of a frame that starts at page P is written to byte address P*256+4+i. The RAM read port returns the byte at `memRdAddr` one clock later.
- R4: When a frame is stored, the block writes its header at bytes 0..3 of its first page. Byte 0 is next[7:0]. Byte 1 is {len[3:0], next[11:8]}. Byte 2 is len[11:4]. Byte 3 is the status byte given with the last data byte. len counts data bytes only.
- R5: The next-page value is the page after the last page the frame used, with wraparound applied. The write-page pointer takes this value one cycle after the cycle that carries the last byte.
- R6: A byte that would fall at (high boundary + 1)*256 is placed at low boundary*256 instead, and the bytes after it follow on from there.
- R7: A frame is dropped when a page it needs equals the read-page pointer, or when its next-page value would equal the read-page pointer. A dropped frame writes no header, leaves the write-page pointer unchanged and sets flag bit 2.
- R8: With automatic recovery off, a drop for lack of space halts reception. Frames are then ignored until software writes 1 to flag bit 2. With automatic recovery on, the next frame is accepted normally.
- R9: Frames of up to 1536 data bytes are stored. A longer frame is discarded with no flag set and no change to the write-page pointer.
- R10: A stored frame sets flag bit 0. It also sets bit 1 if status bit 7 was set. Writing 1 to a flag bit clears it, but a flag set in the same cycle stays set. `irq` is high while any flag is set together with its mask bit.
- R11: Writing the read-page pointer frees every page from its old value up to its new value. When the pointers are equal the region is empty, and those pages accept new frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Frame byte valid |
| rxData | input | 8 | Frame byte |
| rxLast | input | 1 | Marks the last byte of a frame; at least one idle cycle must follow |
| rxStatus | input | 8 | Frame status, taken with the last byte |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 4 | Host register address |
| regWrData | input | 8 | Host register write data |
| regRdData | output | 8 | Host register read data (combinational) |
| memRdAddr | input | 12 | Host RAM byte address |
| memRdData | output | 8 | Host RAM read data, one cycle after the address |
| irq | output | 1 | Masked interrupt request |

## Verification
Two events can land on the same clock edge: the block setting the frame-stored flag when it seals a frame, and software writing 1 to that flag to clear it. The bench places a clear write in the cycle right after the last data byte, which is the cycle in which the header is written and the write pointer moves. It then expects the flag to read 1. A later clear with no frame arriving must read 0. This shows that a set in the same cycle takes priority over the clear and that the clear itself works.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int PTR_W  = 12;
  localparam int OFS_W  = 8;
  localparam int LEN_W  = 12;
  localparam int STAT_W = 8;
  localparam int HDR_W  = 32;
  localparam logic [OFS_W-1:0] DATA_OFS = OFS_W'(4);

  localparam logic [3:0] RA_PTR_TOP = 4'd7;
  localparam logic [3:0] RA_FLAGS   = 4'd8;
  localparam logic [3:0] RA_MASK    = 4'd9;
  localparam logic [3:0] RA_CTRL    = 4'd10;

  localparam int FLAG_W    = 3;
  localparam int FL_STORED = 0;
  localparam int FL_ERROR  = 1;
  localparam int FL_FULL   = 2;

  typedef struct packed {
    logic             byteWe;
    logic [PTR_W-1:0] bytePage;
    logic [OFS_W-1:0] byteOfs;
    logic [7:0]       byteData;
    logic             hdrWe;
    logic [PTR_W-1:0] hdrPage;
    logic [HDR_W-1:0] hdrWord;
    logic             commit;
    logic [PTR_W-1:0] newWrPtr;
    logic             setStored;
    logic             setError;
    logic             setFull;
  } ringStrobes_t;
endpackage

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
  import rx_ring_pkg::*;
#(
  parameter logic [PTR_W-1:0] RESET_BOUND = 12'h001,
  parameter logic [PTR_W-1:0] RESET_HI    = 12'h00F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [3:0]       regAddr,
  input  logic [7:0]       regWrData,
  input  ringStrobes_t     strb,
  output logic [7:0]       regRdData,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [PTR_W-1:0] bound,
  output logic [PTR_W-1:0] hiBound,
  output logic             halted,
  output logic             irq
);
  localparam int NUM_PTR = 4;

  logic [PTR_W-1:0]  ptrQ [NUM_PTR];
  logic [FLAG_W-1:0] flags, mask, setBits, clrBits;
  logic              autoRec, setHalt;
  logic [15:0]       ptrSel;

  genvar k;
  generate
    for (k = 0; k < NUM_PTR; k++) begin : g_ptr
      localparam logic [PTR_W-1:0] RV = (k == 3) ? RESET_HI : RESET_BOUND;
      logic wrLo, wrHi;
      assign wrLo = regWrEn && (regAddr == 4'(2*k));
      assign wrHi = regWrEn && (regAddr == 4'(2*k+1));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          ptrQ[k] <= RV;
        end else begin
          if (wrLo) ptrQ[k][7:0] <= regWrData;
          if (wrHi) ptrQ[k][PTR_W-1:8] <= regWrData[PTR_W-9:0];
          if (k == 0 && strb.commit) ptrQ[k] <= strb.newWrPtr;
        end
      end
    end
  endgenerate

  assign wrPtr   = ptrQ[0];
  assign rdPtr   = ptrQ[1];
  assign bound   = ptrQ[2];
  assign hiBound = ptrQ[3];

  assign setBits = {strb.setFull, strb.setError, strb.setStored};
  assign clrBits = (regWrEn && regAddr == RA_FLAGS) ? regWrData[FLAG_W-1:0] : '0;
  assign setHalt = strb.setFull && !autoRec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags   <= '0;
      mask    <= '0;
      autoRec <= 1'b0;
      halted  <= 1'b0;
    end else begin
      flags  <= (flags & ~clrBits) | setBits;
      halted <= setHalt | (halted & ~clrBits[FL_FULL]);
      if (regWrEn && regAddr == RA_MASK) mask <= regWrData[FLAG_W-1:0];
      if (regWrEn && regAddr == RA_CTRL) autoRec <= regWrData[0];
    end
  end

  assign irq    = |(flags & mask);
  assign ptrSel = 16'(ptrQ[regAddr[2:1]]);

  always_comb begin
    regRdData = '0;
    if (regAddr <= RA_PTR_TOP)  regRdData = regAddr[0] ? ptrSel[15:8] : ptrSel[7:0];
    else if (regAddr == RA_FLAGS) regRdData = 8'(flags);
    else if (regAddr == RA_MASK)  regRdData = 8'(mask);
    else if (regAddr == RA_CTRL)  regRdData = {6'b0, halted, autoRec};
  end

  logic unusedStrb;
  assign unusedStrb = ^strb;

  a_r5_commit_in_region: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (strb.newWrPtr >= bound && strb.newWrPtr <= hiBound));
  a_r7_commit_not_full: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (strb.newWrPtr != rdPtr));
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.setStored |=> flags[FL_STORED]);
  a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !(regWrEn && regAddr == RA_FLAGS && regWrData[FL_FULL])) |=> halted);
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
#(
  parameter int MAX_FRAME = 1536
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  input  logic [STAT_W-1:0] rxStatus,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [PTR_W-1:0]  bound,
  input  logic [PTR_W-1:0]  hiBound,
  input  logic              halted,
  output ringStrobes_t      strb
);
  localparam logic [OFS_W-1:0] OFS_LAST = '1;
  localparam logic [LEN_W-1:0] LEN_CAP  = LEN_W'(MAX_FRAME);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_DROP, ST_SEAL} rxState_t;

  rxState_t          state, nState;
  logic [PTR_W-1:0]  startPage, nStart, curPage, nCur, nxtCur, sealNext;
  logic [OFS_W-1:0]  ofs, nOfs;
  logic [LEN_W-1:0]  lenCnt, nLen;
  logic [STAT_W-1:0] statHold, nStat;

  function automatic logic [PTR_W-1:0] pageAfter(input logic [PTR_W-1:0] p,
                                                 input logic [PTR_W-1:0] lo,
                                                 input logic [PTR_W-1:0] hi);
    return (p == hi) ? lo : p + PTR_W'(1);
  endfunction

  assign nxtCur   = pageAfter(curPage, bound, hiBound);
  assign sealNext = (ofs == '0) ? curPage : nxtCur;

  always_comb begin
    nState = state;
    nStart = startPage;
    nCur   = curPage;
    nOfs   = ofs;
    nLen   = lenCnt;
    nStat  = statHold;
    strb   = '0;
    case (state)
      ST_IDLE: begin
        if (rxValid) begin
          if (halted) begin
            if (!rxLast) nState = ST_DROP;
          end else begin
            strb.byteWe   = 1'b1;
            strb.bytePage = wrPtr;
            strb.byteOfs  = DATA_OFS;
            strb.byteData = rxData;
            nStart = wrPtr;
            nCur   = wrPtr;
            nOfs   = DATA_OFS + OFS_W'(1);
            nLen   = LEN_W'(1);
            nStat  = rxStatus;
            nState = rxLast ? ST_SEAL : ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (rxValid) begin
          if (lenCnt == LEN_CAP) begin
            nState = rxLast ? ST_IDLE : ST_DROP;
          end else begin
            strb.byteWe   = 1'b1;
            strb.bytePage = curPage;
            strb.byteOfs  = ofs;
            strb.byteData = rxData;
            nLen  = lenCnt + LEN_W'(1);
            nStat = rxStatus;
            if (ofs == OFS_LAST && nxtCur == rdPtr) begin
              strb.setFull = 1'b1;
              nState = rxLast ? ST_IDLE : ST_DROP;
            end else begin
              if (ofs == OFS_LAST) nCur = nxtCur;
              nOfs   = ofs + OFS_W'(1);
              nState = rxLast ? ST_SEAL : ST_FILL;
            end
          end
        end
      end
      ST_DROP: begin
        if (rxValid && rxLast) nState = ST_IDLE;
      end
      ST_SEAL: begin
        nState = ST_IDLE;
        if (ofs != '0 && nxtCur == rdPtr) begin
          strb.setFull = 1'b1;
        end else begin
          strb.hdrWe     = 1'b1;
          strb.hdrPage   = startPage;
          strb.hdrWord   = {statHold, lenCnt[11:4], lenCnt[3:0], sealNext[11:8], sealNext[7:0]};
          strb.commit    = 1'b1;
          strb.newWrPtr  = sealNext;
          strb.setStored = 1'b1;
          strb.setError  = statHold[STAT_W-1];
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      startPage <= '0;
      curPage   <= '0;
      ofs       <= '0;
      lenCnt    <= '0;
      statHold  <= '0;
    end else begin
      state     <= nState;
      startPage <= nStart;
      curPage   <= nCur;
      ofs       <= nOfs;
      lenCnt    <= nLen;
      statHold  <= nStat;
    end
  end

  a_r7_new_page_free: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) != ST_IDLE && curPage != $past(curPage))
      |-> curPage != $past(rdPtr));
  a_r9_len_cap: assert property (@(posedge clk) disable iff (!rstN)
    lenCnt <= LEN_CAP);
endmodule

// File: rtl/rx_ring_mem.sv
module rx_ring_mem
  import rx_ring_pkg::*;
#(
  parameter int RAM_PAGES = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  ringStrobes_t                        strb,
  input  logic [$clog2(RAM_PAGES)+OFS_W-1:0]  memRdAddr,
  output logic [7:0]                          memRdData
);
  localparam int PG_W   = $clog2(RAM_PAGES);
  localparam int WORD_W = PG_W + OFS_W - 2;
  localparam int DEPTH  = 1 << WORD_W;
  localparam int LANES  = 4;

  logic [7:0]        laneRd [LANES];
  logic [1:0]        rdLane;
  logic [WORD_W-1:0] wrWord, rdWord;

  assign wrWord = strb.hdrWe ? {strb.hdrPage[PG_W-1:0], (OFS_W-2)'(0)}
                             : {strb.bytePage[PG_W-1:0], strb.byteOfs[OFS_W-1:2]};
  assign rdWord = memRdAddr[PG_W+OFS_W-1:2];

  genvar ln;
  generate
    for (ln = 0; ln < LANES; ln++) begin : g_lane
      logic [7:0] bank [DEPTH];
      logic       laneWe;
      logic [7:0] laneWd;
      assign laneWe = strb.hdrWe || (strb.byteWe && strb.byteOfs[1:0] == 2'(ln));
      assign laneWd = strb.hdrWe ? strb.hdrWord[8*ln +: 8] : strb.byteData;
      always_ff @(posedge clk) begin
        if (laneWe) bank[wrWord] <= laneWd;
        laneRd[ln] <= bank[rdWord];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) rdLane <= '0;
    else       rdLane <= memRdAddr[1:0];
  end

  assign memRdData = laneRd[rdLane];

  logic unusedStrb;
  assign unusedStrb = ^strb;

  a_r4_port_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.hdrWe && strb.byteWe));
endmodule

// File: rtl/rx_page_ring.sv
module rx_page_ring
  import rx_ring_pkg::*;
#(
  parameter int               RAM_PAGES   = 16,
  parameter int               MAX_FRAME   = 1536,
  parameter logic [PTR_W-1:0] RESET_BOUND = 12'h001,
  parameter logic [PTR_W-1:0] RESET_HI    = 12'h00F,
  localparam int              ADDR_W      = $clog2(RAM_PAGES) + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  input  logic [STAT_W-1:0] rxStatus,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [ADDR_W-1:0] memRdAddr,
  output logic [7:0]        memRdData,
  output logic              irq
);
  ringStrobes_t     strb;
  logic [PTR_W-1:0] wrPtr, rdPtr, bound, hiBound;
  logic             halted;

  rx_ring_ctrl #(.MAX_FRAME(MAX_FRAME)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxLast(rxLast),
    .rxStatus(rxStatus), .wrPtr(wrPtr), .rdPtr(rdPtr), .bound(bound),
    .hiBound(hiBound), .halted(halted), .strb(strb)
  );

  rx_ring_regs #(.RESET_BOUND(RESET_BOUND), .RESET_HI(RESET_HI)) u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strb(strb), .regRdData(regRdData), .wrPtr(wrPtr),
    .rdPtr(rdPtr), .bound(bound), .hiBound(hiBound), .halted(halted), .irq(irq)
  );

  rx_ring_mem #(.RAM_PAGES(RAM_PAGES)) u_mem (
    .clk(clk), .rstN(rstN), .strb(strb), .memRdAddr(memRdAddr), .memRdData(memRdData)
  );
endmodule

// File: tb/rx_page_ring_bench.sv
module rx_page_ring_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0, rxLast = 1'b0;
  logic [7:0] rxData = '0, rxStatus = '0;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0, regRdData, memRdData;
  logic [11:0] memRdAddr = '0;
  logic       irq;

  int errCnt = 0, chkCnt = 0;
  int bBound = 1, bHi = 15;
  bit monBusy = 1'b0, finished = 1'b0;

  typedef struct { int addr; int exp; string tag; } memItem_t;
  memItem_t sbq[$];

  always #2 clk = ~clk;

  rx_page_ring u_rx_page_ring (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxLast(rxLast),
    .rxStatus(rxStatus), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .memRdAddr(memRdAddr), .memRdData(memRdData), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected RAM bytes and compares them at the read port
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        memItem_t it;
        monBusy = 1'b1;
        it = sbq.pop_front();
        memRdAddr = 12'(it.addr);
        @(negedge clk);
        chk(it.tag, int'(memRdData), it.exp);
        monBusy = 1'b0;
      end
    end
  end

  task automatic drain();
    while (sbq.size() != 0 || monBusy) @(negedge clk);
  endtask

  function automatic int pageAfter(input int p);
    return (p == bHi) ? bBound : p + 1;
  endfunction

  function automatic int dataAddr(input int start, input int i);
    int a, lim;
    a = start * 256 + 4 + i;
    lim = (bHi + 1) * 256;
    if (a >= lim) a = a - lim + bBound * 256;
    return a;
  endfunction

  // driver side of the scoreboard: expected header and data bytes
  task automatic expectFrame(input int start, input int len, input int st,
                             input int seed, input string tag);
    int nxt;
    nxt = pageAfter(dataAddr(start, len - 1) >> 8);
    sbq.push_back('{(start * 256) & 12'hFFF, nxt & 8'hFF, "R4 hdr byte0"});
    sbq.push_back('{(start * 256 + 1) & 12'hFFF, ((len & 15) << 4) | (nxt >> 8), "R4 hdr byte1"});
    sbq.push_back('{(start * 256 + 2) & 12'hFFF, (len >> 4) & 8'hFF, "R4 hdr byte2"});
    sbq.push_back('{(start * 256 + 3) & 12'hFFF, st, "R4 hdr byte3"});
    for (int i = 0; i < len; i++)
      sbq.push_back('{dataAddr(start, i) & 12'hFFF, (seed + i) & 8'hFF, tag});
  endtask

  task automatic regWrite(input int a, input int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'(a); regWrData = 8'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input int a, output int v);
    @(negedge clk);
    regAddr = 4'(a);
    #1 v = int'(regRdData);
  endtask

  task automatic readPtr(input int base, output int v);
    int lo, hi;
    regRead(base, lo);
    regRead(base + 1, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic sendFrame(input int len, input int st, input int seed, input bit clrAtSeal);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxData = 8'(seed + i); rxLast = (i == len - 1); rxStatus = 8'(st);
    end
    @(negedge clk);
    rxValid = 1'b0; rxLast = 1'b0;
    if (clrAtSeal) begin
      regWrEn = 1'b1; regAddr = 4'd8; regWrData = 8'h01;
    end
    @(negedge clk);
    regWrEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errCnt++; chkCnt++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int v;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readPtr(0, v); chk("R1 wrPtr", v, 1);
    readPtr(2, v); chk("R1 rdPtr", v, 1);
    readPtr(4, v); chk("R1 bound", v, 1);
    readPtr(6, v); chk("R1 hiBound", v, 15);
    regRead(8, v); chk("R1 flags", v, 0);
    regRead(10, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", int'(irq), 0);
    regWrite(9, 7);

    // R3/R5: short frame at page 1
    sendFrame(10, 8'h20, 8'h10, 1'b0);
    expectFrame(1, 10, 8'h20, 8'h10, "R3 data");
    readPtr(0, v); chk("R5 wrPtr after short frame", v, 2);
    regRead(8, v); chk("R10 stored flag", v, 1);
    chk("R10 irq high", int'(irq), 1);
    drain();

    // frame ending exactly at a page end, receive error status
    sendFrame(252, 8'h81, 8'h40, 1'b0);
    expectFrame(2, 252, 8'h81, 8'h40, "R5 data page end");
    readPtr(0, v); chk("R5 wrPtr after page-end frame", v, 3);
    regRead(8, v); chk("R10 error flag", v, 3);
    drain();
    regWrite(8, 3);
    regRead(8, v); chk("R10 flags cleared", v, 0);
    chk("R10 irq low", int'(irq), 0);

    sendFrame(300, 8'h00, 8'h77, 1'b0);
    expectFrame(3, 300, 8'h00, 8'h77, "R3 two pages");
    readPtr(0, v); chk("R5 wrPtr two pages", v, 5);
    drain();

    sendFrame(1536, 8'h01, 8'h05, 1'b0);
    expectFrame(5, 1536, 8'h01, 8'h05, "R9 max frame");
    readPtr(0, v); chk("R9 wrPtr after max frame", v, 12);
    drain();

    // R11 free pages 1..4; upper nibble write check (R2)
    regWrite(2, 5);
    regWrite(3, 8'hF0);
    regRead(3, v); chk("R2 upper nibble only", v, 0);
    readPtr(2, v); chk("R11 rdPtr written", v, 5);

    // R6 wraparound from page 15 to page 1
    sendFrame(1100, 8'h02, 8'h99, 1'b0);
    expectFrame(12, 1100, 8'h02, 8'h99, "R6 wrapped data");
    readPtr(0, v); chk("R6 wrPtr after wrap", v, 2);
    drain();
    regWrite(8, 7);

    // R7 overflow into the read page
    sendFrame(800, 8'h00, 8'h11, 1'b0);
    readPtr(0, v); chk("R7 wrPtr kept", v, 2);
    regRead(8, v); chk("R7 full flag", v, 4);
    regRead(10, v); chk("R8 halted", v, 2);
    // R8 halted: frame ignored
    sendFrame(10, 8'h00, 8'h22, 1'b0);
    readPtr(0, v); chk("R8 ignored frame wrPtr", v, 2);
    regRead(8, v); chk("R8 ignored frame flags", v, 4);
    regWrite(8, 4);
    regRead(10, v); chk("R8 released", v, 0);
    sendFrame(10, 8'h00, 8'h33, 1'b0);
    expectFrame(2, 10, 8'h00, 8'h33, "R8 after release");
    readPtr(0, v); chk("R8 wrPtr after release", v, 3);
    drain();

    sendFrame(252, 8'h00, 8'h44, 1'b0);
    readPtr(0, v); chk("R5 wrPtr page 3 filled", v, 4);
    // R7 next pointer would meet the read page
    sendFrame(100, 8'h00, 8'h55, 1'b0);
    readPtr(0, v); chk("R7 seal-time full wrPtr", v, 4);
    regRead(8, v); chk("R7 seal-time full flags", v, 5);

    // R8 automatic recovery
    regWrite(10, 1);
    regWrite(8, 7);
    sendFrame(100, 8'h00, 8'h66, 1'b0);
    regRead(8, v); chk("R8 auto full flag", v, 4);
    regRead(10, v); chk("R8 auto not halted", v, 1);
    regWrite(2, 4);
    regWrite(3, 0);
    sendFrame(20, 8'h03, 8'h70, 1'b0);
    expectFrame(4, 20, 8'h03, 8'h70, "R11 reuse freed page");
    readPtr(0, v); chk("R8 auto accepted wrPtr", v, 5);
    drain();
    regWrite(8, 7);

    // R9 overlong frame
    sendFrame(1537, 8'h00, 8'h01, 1'b0);
    readPtr(0, v); chk("R9 overlong wrPtr", v, 5);
    regRead(8, v); chk("R9 overlong flags", v, 0);

    // R10 set and clear in the same cycle
    sendFrame(8, 8'h00, 8'hA0, 1'b1);
    regRead(8, v); chk("R10 set beats clear", v, 1);
    readPtr(0, v); chk("R5 wrPtr after small frame", v, 6);
    expectFrame(5, 8, 8'h00, 8'hA0, "R3 small frame");
    drain();
    regWrite(8, 1);
    regRead(8, v); chk("R10 clear alone", v, 0);

    finish();
  end
endmodule